// File: doc/BRIEF.md
# ADC Startup Mute Sequencer

This block sits on the digital output of a two-channel capture converter and holds both channels silent while the converter settles after power-up. It watches the left and right channel enables. When either one turns on while both were off, it starts a settling window of a fixed number of sample periods and drives both output words to two's-complement zero for the whole window. Once the window ends, converted samples pass through unchanged.

The window length is picked by a single select input: a long window of 1059 sample periods or a short one of 267. The select is captured when the window starts, so later changes do not alter a window in progress. Sample periods are counted from a one-cycle sample strobe. Samples from a digital microphone front end go through the same port and receive the same gating as converter samples. Turning both enables off cancels a window, and the next enable starts a new full window.

Top module: `adc_start_mute`

## Requirements
- R1: When either enable is 1 in a cycle and both enables were 0 in the previous cycle (or reset was active), `busy` is 1 from the next cycle on.
- R2: With `short_sel` = 0 at the start, `busy` falls in the cycle after the 1059th sample strobe that comes after the start cycle. A strobe in the start cycle is not counted.
- R3: With `short_sel` = 1 at the start, `busy` falls in the cycle after the 267th sample strobe that comes after the start cycle.
- R4: Each output word is zero one cycle after any cycle in which the window is starting or running.
- R5: At all other times with an enable on, `out_l`/`out_r` equal `in_l`/`in_r` from one cycle earlier. `out_valid` always equals `in_valid` from one cycle earlier.
- R6: Setting the second enable while the first is already on does not restart the window. The total strobe count stays as chosen at the start.
- R7: If both enables are 0, `busy` is 0 in the next cycle and the count is dropped. The next enable starts a full new window.
- R8: Changes of `short_sel` after the start cycle do not change the length of the running window.
- R9: A synchronous active-high `rst` sets `busy`, `out_valid`, `out_l` and `out_r` to 0 in the next cycle. The window is cancelled.
- R10: While both enables are 0, both output words are zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_l | input | 1 | Left channel power enable |
| en_r | input | 1 | Right channel power enable |
| short_sel | input | 1 | Window length select: 0 = 1059 periods, 1 = 267 periods |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| in_valid | input | 1 | Input sample words are valid |
| in_l | input | DATA_W | Left input sample, two's complement |
| in_r | input | DATA_W | Right input sample, two's complement |
| out_valid | output | 1 | Output sample words are valid |
| out_l | output | DATA_W | Left output sample |
| out_r | output | DATA_W | Right output sample |
| busy | output | 1 | Settling window is active |

## Verification
The data path has one register stage. Every sample word and valid flag driven in a cycle is due on the outputs after the next rising edge. `busy` shows a start, a final strobe or a cancel in the cycle after the edge that saw it. The driver applies inputs on the falling edge and pushes the expected outputs for that cycle into a queue. The monitor pops one entry at one time unit after each rising edge, so every comparison is made exactly one register stage after its stimulus. The window-length checks give one strobe per two cycles and read `busy` on the falling edge after each strobe's rising edge. This counts how many strobes it takes for `busy` to drop.

// File: rtl/adc_start_mute_pkg.sv
package adc_start_mute_pkg;

    typedef struct packed {
        logic any_on;
    } det_state_t;

    typedef enum logic {
        LEN_LONG  = 1'b0,
        LEN_SHORT = 1'b1
    } len_sel_e;

endpackage

// File: rtl/mute_start_detect.sv
module mute_start_detect
    import adc_start_mute_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_l,
    input  logic en_r,
    output logic start,
    output logic all_off
);

    det_state_t st_d, st_q;
    logic       any_now;

    always_comb begin
        any_now   = en_l | en_r;
        st_d      = st_q;
        st_d.any_on = any_now;
        start     = any_now & ~st_q.any_on;
        all_off   = ~any_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.any_on <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mute_init_timer.sv
module mute_init_timer
    import adc_start_mute_pkg::*;
#(
    parameter int LONG_CYC  = 1059,
    parameter int SHORT_CYC = 267
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    input  logic short_sel,
    input  logic smp_stb,
    output logic busy
);

    localparam int CNT_W = (LONG_CYC > SHORT_CYC) ? $clog2(LONG_CYC) : $clog2(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    len_sel_e   sel;

    always_comb begin
        sel  = len_sel_e'(short_sel);
        st_d = st_q;
        if (cancel) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.last = (sel == LEN_SHORT) ? SHORT_LAST : LONG_LAST;
        end else if (st_q.busy && smp_stb) begin
            if (st_q.cnt == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
            st_q.last <= LONG_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/mute_out_gate.sv
module mute_out_gate #(
    parameter int DATA_W = 24,
    parameter int NUM_CH = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mute,
    input  logic                          in_valid,
    input  logic [NUM_CH-1:0][DATA_W-1:0] in_data,
    output logic                          out_valid,
    output logic [NUM_CH-1:0][DATA_W-1:0] out_data
);

    typedef struct packed {
        logic                          vld;
        logic [NUM_CH-1:0][DATA_W-1:0] dat;
    } gate_state_t;

    gate_state_t                   st_d, st_q;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_next;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_next[c] = mute ? '0 : in_data[c];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.dat = ch_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= 1'b0;
            st_q.dat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

endmodule

// File: rtl/adc_start_mute.sv
module adc_start_mute
    import adc_start_mute_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int LONG_CYC  = 1059,
    parameter int SHORT_CYC = 267
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_l,
    input  logic              en_r,
    input  logic              short_sel,
    input  logic              smp_stb,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              busy
);

    localparam int NUM_CH = 2;

    logic                          start;
    logic                          all_off;
    logic                          tmr_busy;
    logic                          mute;
    logic [NUM_CH-1:0][DATA_W-1:0] in_pack;
    logic [NUM_CH-1:0][DATA_W-1:0] out_pack;

    mute_start_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .en_l    (en_l),
        .en_r    (en_r),
        .start   (start),
        .all_off (all_off)
    );

    mute_init_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cancel    (all_off),
        .short_sel (short_sel),
        .smp_stb   (smp_stb),
        .busy      (tmr_busy)
    );

    assign mute       = tmr_busy | start | all_off;
    assign in_pack[0] = in_l;
    assign in_pack[1] = in_r;

    mute_out_gate #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .mute      (mute),
        .in_valid  (in_valid),
        .in_data   (in_pack),
        .out_valid (out_valid),
        .out_data  (out_pack)
    );

    assign out_l = out_pack[0];
    assign out_r = out_pack[1];
    assign busy  = tmr_busy;

endmodule

// File: rtl/adc_start_mute_chk.sv
module adc_start_mute_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              en_l,
    input logic              en_r,
    input logic              smp_stb,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r,
    input logic              busy
);

    logic prev_any;
    logic any_now;

    assign any_now = en_l | en_r;

    always_ff @(posedge clk) begin
        if (rst) prev_any <= 1'b0;
        else     prev_any <= any_now;
    end

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        (any_now && !prev_any) |=> busy);                                  // R1

    AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(any_now && !prev_any));                      // R1

    AST_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(smp_stb) || !$past(any_now)));              // R2

    AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (rst)
        busy |-> (out_l == '0 && out_r == '0));                            // R4

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                           // R5

    AST_INVALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                         // R5

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && prev_any && any_now && !smp_stb) |=> busy);               // R6

    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        !any_now |=> !busy);                                               // R7

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !any_now |=> (out_l == '0 && out_r == '0));                        // R10

endmodule

bind adc_start_mute adc_start_mute_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .en_l      (en_l),
    .en_r      (en_r),
    .smp_stb   (smp_stb),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r),
    .busy      (busy)
);

// File: tb/adc_start_mute_tb.sv
module adc_start_mute_tb_top;

    localparam int DW      = 24;
    localparam int N_LONG  = 1059;
    localparam int N_SHORT = 267;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_l = 1'b0, en_r = 1'b0, short_sel = 1'b0, smp_stb = 1'b0, in_valid = 1'b0;
    logic [DW-1:0] in_l = '0, in_r = '0;
    logic          out_valid, busy;
    logic [DW-1:0] out_l, out_r;

    always #2 clk = ~clk;

    adc_start_mute dut_i (
        .clk(clk), .rst(rst), .en_l(en_l), .en_r(en_r), .short_sel(short_sel),
        .smp_stb(smp_stb), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .busy(busy)
    );

    typedef struct {
        logic          v;
        logic [DW-1:0] l;
        logic [DW-1:0] r;
        logic          b;
        string         req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R9";
    bit    finished = 0;

    bit m_prev = 0, m_busy = 0;
    int m_cnt = 0, m_len = N_LONG;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit el, input bit er, input bit sel,
                        input bit stb, input bit vld);
        item_t it;
        bit    st, off, mute;
        logic [DW-1:0] dl, dr;
        @(negedge clk);
        dl = DW'($urandom) | DW'(1);
        dr = DW'($urandom) | DW'(2);
        rst = r; en_l = el; en_r = er; short_sel = sel; smp_stb = stb;
        in_valid = vld; in_l = dl; in_r = dr;
        it.req = cur_req;
        if (r) begin
            m_prev = 0; m_busy = 0; m_cnt = 0; m_len = N_LONG;
            it.v = 0; it.l = '0; it.r = '0; it.b = 0;
        end else begin
            off  = !(el || er);
            st   = (el || er) && !m_prev;
            mute = m_busy || st || off;
            it.v = vld;
            it.l = mute ? '0 : dl;
            it.r = mute ? '0 : dr;
            if (off) begin
                m_busy = 0; m_cnt = 0;
            end else if (st) begin
                m_busy = 1; m_cnt = 0; m_len = sel ? N_SHORT : N_LONG;
            end else if (m_busy && stb) begin
                if (m_cnt == m_len - 1) begin m_busy = 0; m_cnt = 0; end
                else m_cnt++;
            end
            m_prev = el || er;
            it.b = m_busy;
        end
        q.push_back(it);
    endtask

    always @(posedge clk) begin
        item_t it;
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_checks++;
            if (out_valid !== it.v || out_l !== it.l || out_r !== it.r || busy !== it.b) begin
                n_fail++;
                $display("FAIL %s actual v=%0b l=%h r=%h busy=%0b expected v=%0b l=%h r=%h busy=%0b",
                         it.req, out_valid, out_l, out_r, busy, it.v, it.l, it.r, it.b);
            end
        end
    end

    task automatic run_count(input bit sel0, input bit flip, input bit add_r,
                             input int exp_n, input string req);
        int n = 0;
        bit sel_now, er_now;
        while (n < 1300) begin
            sel_now = (flip && n >= 3) ? !sel0 : sel0;
            er_now  = add_r && n >= 5;
            step(0, 1, er_now, sel_now, 1, 1);
            step(0, 1, er_now, sel_now, 0, 1);
            n++;
            if (busy !== 1'b1) break;
        end
        chk(n == exp_n, req, n, exp_n);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        cur_req = "R9";
        repeat (3) step(1, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0);
        chk(busy === 1'b0 && out_valid === 1'b0 && out_l === '0, "R9", busy, 0);

        // R10: both enables off keep outputs silent, valid still passes (R5)
        cur_req = "R10";
        repeat (6) step(0, 0, 0, 0, 1, 1);

        // R1/R2/R4: long window from left enable
        cur_req = "R4";
        step(0, 1, 0, 0, 1, 1);
        step(0, 1, 0, 0, 0, 1);
        chk(busy === 1'b1, "R1", busy, 1);
        run_count(0, 0, 0, N_LONG, "R2");

        // R5: pass-through after window, mixed valid
        cur_req = "R5";
        for (int i = 0; i < 10; i++) step(0, 1, 0, 0, i % 3 == 0, i % 2);

        // R7: cancel, then R3/R6/R8 short window with select flip and second enable
        cur_req = "R7";
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        chk(busy === 1'b0, "R7", busy, 0);
        cur_req = "R8";
        step(0, 0, 1, 1, 0, 1);
        run_count(1, 1, 0, N_SHORT, "R8");
        cur_req = "R6";
        step(0, 0, 0, 0, 0, 1);
        step(0, 1, 0, 1, 0, 1);
        run_count(1, 0, 1, N_SHORT, "R6");
        cur_req = "R3";
        step(0, 0, 0, 1, 0, 1);
        step(0, 0, 1, 1, 0, 1);
        run_count(1, 0, 0, N_SHORT, "R3");

        // R7: abort mid-window then fresh full count
        cur_req = "R7";
        step(0, 0, 0, 1, 0, 1);
        step(0, 1, 0, 1, 0, 1);
        for (int i = 0; i < 100; i++) begin
            step(0, 1, 0, 1, 1, 1);
            step(0, 1, 0, 1, 0, 1);
        end
        chk(busy === 1'b1, "R7", busy, 1);
        step(0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 1, 0, 1);
        chk(busy === 1'b0, "R7", busy, 0);
        step(0, 1, 1, 1, 0, 1);
        run_count(1, 0, 0, N_SHORT, "R7");

        // R9: reset in the middle of a window
        cur_req = "R9";
        step(0, 0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 1, 1);
        step(1, 1, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0);
        chk(busy === 1'b0 && out_valid === 1'b0, "R9", busy, 0);
        repeat (4) step(0, 0, 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule